// File: doc/BRIEF.md
# Coprocessor Operand Register File and Move Decoder

This block sits on the bus side of an arithmetic coprocessor. It holds the coprocessor's architectural state: a Control word, two operands that are each two words wide (Left/Leftx and Right/Rightx), and the result pair that an attached arithmetic engine computes from that state. Each cycle a command may arrive. It carries a valid bit, a function-write bit and a 4-bit move code, plus two data words. `data_a` belongs to the first half of the cycle and `data_b` to the second half. The move code either loads registers from the bus, copies the result pair back into an operand, or reads a register out onto a registered read port.

The command port follows valid/ready rules. A command is accepted in any cycle where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` falls only for the four result-consuming codes, and only while the engine has not finished the computation for the current state. While `cmd_ready` is low, the source holds the same command and data stable until it is accepted. Any accepted write pulses `eng_restart` on the following cycle, which tells the engine to start again on the new state. The engine reports completion on `eng_done`, along with its exception flags. When a result-consuming command is accepted and an enabled exception flag is set, `fault` is raised in that cycle and the data move is suppressed.

Top module: `copro_regfile`

## Requirements
- R1: Code 0 loads Left from `data_b`. Code 1 loads Left from `data_b` and Leftx from `data_a`. Code 2 loads Right from `data_b`. Code 3 loads Right from `data_b` and Rightx from `data_a`. The new values are visible on the `op_*` outputs after the accepting clock edge.
- R2: Code 4 loads the whole Control word from `data_b`. Code 5 loads Left from `data_b` and Right from `data_a`.
- R3: Code 6 copies `eng_res`/`eng_resx` into Left/Leftx. Code 7 copies them into Right/Rightx.
- R4: Codes 8, 9, 10, 11 and 12 read out Left, Leftx, Right, Rightx and Control. Codes 14 and 15 read out `eng_res` and `eng_resx`. Code 13 reads zero. The value sampled at acceptance appears on `rd_data`, with `rd_valid` high, exactly one cycle later.
- R5: When `cmd_wfunc` is set on an accepted command, Control bits 7:0 (the function byte) load from `data_a[7:0]`. If code 4 is accepted in the same cycle, the `data_b` value wins for the whole word.
- R6: A function write combined with code 1, 3 or 5 is illegal. Its function write is ignored, while the code's own move still takes place.
- R7: Codes 6, 7, 14 and 15 hold `cmd_ready` low until the result for the current state is complete. All other codes are always ready and never fault.
- R8: Control packs the mask in bits 31:24, the flags in 23:16, the mode in 15:8 and the function in 7:0. Flag bit 0 is invalid, bit 1 is divide-by-zero, bit 2 is overflow, bit 3 is underflow, bit 4 is inexact and bit 5 is fixed divide overflow. `eng_flags` uses the same order. On every accepted result-consuming command, `eng_flags` is ORed into the flag byte.
- R9: If an accepted result-consuming command finds a nonzero AND of the merged flag byte and the mask byte, `fault` is high in that cycle, no operand changes and no read is returned.
- R10: Every accepted write (codes 0–7, or a legal function write) raises `eng_restart` for one cycle after the edge. Results are then not ready until `eng_done` is seen after that pulse.
- R11: After reset, all registers read zero, `rd_valid` is low and a computation is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be accepted this cycle |
| cmd_wfunc | input | 1 | Load function byte from `data_a` |
| cmd_code | input | 4 | Move code |
| data_a | input | 32 | First-half data word |
| data_b | input | 32 | Second-half data word |
| fault | output | 1 | Enabled exception on an accepted result command |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| op_left | output | 32 | Left operand |
| op_leftx | output | 32 | Left extension |
| op_right | output | 32 | Right operand |
| op_rightx | output | 32 | Right extension |
| op_ctrl | output | 32 | Control word |
| eng_restart | output | 1 | Restart pulse to the engine |
| eng_done | input | 1 | Engine result complete |
| eng_res | input | 32 | Engine result word |
| eng_resx | input | 32 | Engine result extension |
| eng_flags | input | 6 | Engine exception flags |

## Verification
Two pairs of functions can land in the same cycle. The first pair is a function-byte write together with a full Control write (code 4 plus `cmd_wfunc`); it is judged by reading Control back and expecting the `data_b` word. The second pair is a flag merge together with a fault on a result copy; it is provoked by enabling a mask bit while the engine reports that flag. It is judged by expecting `fault` high, unchanged operands, no read, and the merged flag visible in Control afterwards. A behavioural model in the bench predicts every output on every clock, including the cycles in which the command is rejected.

// File: rtl/copro_pkg.sv
package copro_pkg;
  localparam int N_OPS = 4;
  localparam int OP_L  = 0;
  localparam int OP_LX = 1;
  localparam int OP_R  = 2;
  localparam int OP_RX = 3;

  typedef enum logic [3:0] {
    MV_LEFT = 4'd0, MV_LEFT_PAIR = 4'd1, MV_RIGHT = 4'd2, MV_RIGHT_PAIR = 4'd3,
    MV_CTRL = 4'd4, MV_LR = 4'd5, MV_RES2L = 4'd6, MV_RES2R = 4'd7,
    RD_LEFT = 4'd8, RD_LEFTX = 4'd9, RD_RIGHT = 4'd10, RD_RIGHTX = 4'd11,
    RD_CTRL = 4'd12, RD_NONE = 4'd13, RD_RES = 4'd14, RD_RESX = 4'd15
  } mv_code_e;

  typedef enum logic [1:0] {SRC_KEEP, SRC_A, SRC_B, SRC_ENG} src_e;

  typedef enum logic [2:0] {
    RS_LEFT, RS_LEFTX, RS_RIGHT, RS_RIGHTX, RS_CTRL, RS_ZERO, RS_RES, RS_RESX
  } rsel_e;

  typedef struct packed {
    src_e [N_OPS-1:0] op_src;
    logic             ctrl_ld;
    logic             func_ok;
    logic             is_read;
    rsel_e            rsel;
    logic             need_res;
    logic             is_write;
  } dec_t;
endpackage

// File: rtl/copro_cmd_decode.sv
module copro_cmd_decode
  import copro_pkg::*;
(
  input  logic [3:0] code,
  output dec_t       dec
);
  always_comb begin
    dec          = '0;
    dec.func_ok  = 1'b1;
    dec.rsel     = RS_ZERO;
    unique case (code)
      MV_LEFT: begin
        dec.op_src[OP_L] = SRC_B;
        dec.is_write     = 1'b1;
      end
      MV_LEFT_PAIR: begin
        dec.op_src[OP_L]  = SRC_B;
        dec.op_src[OP_LX] = SRC_A;
        dec.is_write      = 1'b1;
        dec.func_ok       = 1'b0;
      end
      MV_RIGHT: begin
        dec.op_src[OP_R] = SRC_B;
        dec.is_write     = 1'b1;
      end
      MV_RIGHT_PAIR: begin
        dec.op_src[OP_R]  = SRC_B;
        dec.op_src[OP_RX] = SRC_A;
        dec.is_write      = 1'b1;
        dec.func_ok       = 1'b0;
      end
      MV_CTRL: begin
        dec.ctrl_ld  = 1'b1;
        dec.is_write = 1'b1;
      end
      MV_LR: begin
        dec.op_src[OP_L] = SRC_B;
        dec.op_src[OP_R] = SRC_A;
        dec.is_write     = 1'b1;
        dec.func_ok      = 1'b0;
      end
      MV_RES2L: begin
        dec.op_src[OP_L]  = SRC_ENG;
        dec.op_src[OP_LX] = SRC_ENG;
        dec.is_write      = 1'b1;
        dec.need_res      = 1'b1;
      end
      MV_RES2R: begin
        dec.op_src[OP_R]  = SRC_ENG;
        dec.op_src[OP_RX] = SRC_ENG;
        dec.is_write      = 1'b1;
        dec.need_res      = 1'b1;
      end
      RD_LEFT:   begin dec.is_read = 1'b1; dec.rsel = RS_LEFT;   end
      RD_LEFTX:  begin dec.is_read = 1'b1; dec.rsel = RS_LEFTX;  end
      RD_RIGHT:  begin dec.is_read = 1'b1; dec.rsel = RS_RIGHT;  end
      RD_RIGHTX: begin dec.is_read = 1'b1; dec.rsel = RS_RIGHTX; end
      RD_CTRL:   begin dec.is_read = 1'b1; dec.rsel = RS_CTRL;   end
      RD_NONE:   begin dec.is_read = 1'b1; dec.rsel = RS_ZERO;   end
      RD_RES: begin
        dec.is_read  = 1'b1;
        dec.rsel     = RS_RES;
        dec.need_res = 1'b1;
      end
      default: begin
        dec.is_read  = 1'b1;
        dec.rsel     = RS_RESX;
        dec.need_res = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/copro_operand_bank.sv
module copro_operand_bank
  import copro_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       commit,
  input  src_e [N_OPS-1:0]           src,
  input  logic [DW-1:0]              data_a,
  input  logic [DW-1:0]              data_b,
  input  logic [DW-1:0]              eng_res,
  input  logic [DW-1:0]              eng_resx,
  output logic [N_OPS-1:0][DW-1:0]   ops
);
  // even slots are primary words, odd slots are extension words
  for (genvar i = 0; i < N_OPS; i++) begin : g_op
    logic [DW-1:0] q;
    logic [DW-1:0] eng_v;
    assign eng_v  = ((i % 2) == 0) ? eng_res : eng_resx;
    assign ops[i] = q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        q <= '0;
      end else if (commit) begin
        case (src[i])
          SRC_A:   q <= data_a;
          SRC_B:   q <= data_b;
          SRC_ENG: q <= eng_v;
          default: q <= q;
        endcase
      end
    end
  end
endmodule

// File: rtl/copro_ctrl_reg.sv
module copro_ctrl_reg #(
  parameter int DW     = 32,
  parameter int FLAG_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_full,
  input  logic [DW-1:0]     full_val,
  input  logic              ld_func,
  input  logic [DW/4-1:0]   func_val,
  input  logic              merge,
  input  logic [FLAG_W-1:0] eng_flags,
  output logic [DW-1:0]     ctrl,
  output logic              fault_hit
);
  localparam int BW      = DW / 4;
  localparam int FLAG_LO = 2 * BW;
  localparam int MASK_LO = 3 * BW;

  logic [DW-1:0] q;
  logic [BW-1:0] flags_ext;
  logic [BW-1:0] merged;

  assign flags_ext = {{(BW-FLAG_W){1'b0}}, eng_flags};
  assign merged    = q[FLAG_LO +: BW] | flags_ext;
  assign fault_hit = |(merged & q[MASK_LO +: BW]);
  assign ctrl      = q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q <= '0;
    end else if (ld_full) begin
      q <= full_val;
    end else begin
      if (ld_func) q[BW-1:0]        <= func_val;
      if (merge)   q[FLAG_LO +: BW] <= merged;
    end
  end
endmodule

// File: rtl/copro_result_tracker.sv
module copro_result_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic wrote,
  input  logic eng_done,
  output logic res_ok,
  output logic eng_restart
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_ok      <= 1'b0;
      eng_restart <= 1'b1;
    end else begin
      eng_restart <= wrote;
      if (wrote)                         res_ok <= 1'b0;
      else if (eng_done && !eng_restart) res_ok <= 1'b1;
    end
  end

  // R10
  restart_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrote |=> !res_ok);
endmodule

// File: rtl/copro_regfile.sv
module copro_regfile
  import copro_pkg::*;
#(
  parameter int DW     = 32,
  parameter int FLAG_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_wfunc,
  input  logic [3:0]        cmd_code,
  input  logic [DW-1:0]     data_a,
  input  logic [DW-1:0]     data_b,
  output logic              fault,
  output logic              rd_valid,
  output logic [DW-1:0]     rd_data,
  output logic [DW-1:0]     op_left,
  output logic [DW-1:0]     op_leftx,
  output logic [DW-1:0]     op_right,
  output logic [DW-1:0]     op_rightx,
  output logic [DW-1:0]     op_ctrl,
  output logic              eng_restart,
  input  logic              eng_done,
  input  logic [DW-1:0]     eng_res,
  input  logic [DW-1:0]     eng_resx,
  input  logic [FLAG_W-1:0] eng_flags
);
  localparam int BW = DW / 4;

  dec_t                     dec;
  logic                     res_ok;
  logic                     accept;
  logic                     commit;
  logic                     func_ld;
  logic                     wrote;
  logic                     fault_hit;
  logic [N_OPS-1:0][DW-1:0] ops;
  logic [DW-1:0]            rd_mux;

  copro_cmd_decode u_dec (.code(cmd_code), .dec(dec));

  assign cmd_ready = !(dec.need_res && !res_ok);
  assign accept    = cmd_valid && cmd_ready;
  assign fault     = accept && dec.need_res && fault_hit;
  assign commit    = accept && !fault;
  assign func_ld   = accept && cmd_wfunc && dec.func_ok;
  assign wrote     = (commit && dec.is_write) || func_ld;

  copro_operand_bank #(.DW(DW)) u_ops (
    .clk(clk), .rst_n(rst_n), .commit(commit), .src(dec.op_src),
    .data_a(data_a), .data_b(data_b), .eng_res(eng_res), .eng_resx(eng_resx),
    .ops(ops)
  );

  copro_ctrl_reg #(.DW(DW), .FLAG_W(FLAG_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .ld_full(commit && dec.ctrl_ld), .full_val(data_b),
    .ld_func(func_ld), .func_val(data_a[BW-1:0]),
    .merge(accept && dec.need_res), .eng_flags(eng_flags),
    .ctrl(op_ctrl), .fault_hit(fault_hit)
  );

  copro_result_tracker u_trk (
    .clk(clk), .rst_n(rst_n), .wrote(wrote), .eng_done(eng_done),
    .res_ok(res_ok), .eng_restart(eng_restart)
  );

  assign op_left   = ops[OP_L];
  assign op_leftx  = ops[OP_LX];
  assign op_right  = ops[OP_R];
  assign op_rightx = ops[OP_RX];

  always_comb begin
    unique case (dec.rsel)
      RS_LEFT:   rd_mux = ops[OP_L];
      RS_LEFTX:  rd_mux = ops[OP_LX];
      RS_RIGHT:  rd_mux = ops[OP_R];
      RS_RIGHTX: rd_mux = ops[OP_RX];
      RS_CTRL:   rd_mux = op_ctrl;
      RS_RES:    rd_mux = eng_res;
      RS_RESX:   rd_mux = eng_resx;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= commit && dec.is_read;
      if (commit && dec.is_read) rd_data <= rd_mux;
    end
  end

  // R7
  nonresult_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_code inside {4'd6, 4'd7, 4'd14, 4'd15}) |-> cmd_ready);
  // R7
  result_after_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_restart && cmd_code inside {4'd6, 4'd7, 4'd14, 4'd15}) |-> !cmd_ready);
  // R9
  fault_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> ($stable(op_left) && $stable(op_leftx) && $stable(op_right) && $stable(op_rightx)));
  // R9
  fault_noread_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> !rd_valid);
  // R4
  read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && !fault && cmd_code[3]) |=> rd_valid);
  // R10
  restart_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(op_left) |-> eng_restart);
endmodule

// File: tb/tb_copro_regfile.sv
module tb_copro_regfile;
  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_wfunc = 1'b0;
  logic [3:0]  cmd_code = 4'd0;
  logic [31:0] data_a = '0, data_b = '0;
  logic        cmd_ready, fault, rd_valid, eng_restart, eng_done;
  logic [31:0] rd_data, op_left, op_leftx, op_right, op_rightx, op_ctrl;
  logic [31:0] eng_res, eng_resx;
  logic [5:0]  eflags = '0;
  int          cnt;
  int          n_chk = 0, n_fail = 0;
  bit          finished = 0;

  always #10 clk = ~clk;

  copro_regfile dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_wfunc(cmd_wfunc), .cmd_code(cmd_code), .data_a(data_a), .data_b(data_b),
    .fault(fault), .rd_valid(rd_valid), .rd_data(rd_data),
    .op_left(op_left), .op_leftx(op_leftx), .op_right(op_right), .op_rightx(op_rightx),
    .op_ctrl(op_ctrl), .eng_restart(eng_restart), .eng_done(eng_done),
    .eng_res(eng_res), .eng_resx(eng_resx), .eng_flags(eflags)
  );

  // stand-in engine: fixed latency after each restart pulse
  assign eng_res  = op_left + op_right;
  assign eng_resx = op_leftx ^ op_rightx;
  assign eng_done = (cnt == 0);
  always_ff @(posedge clk) begin
    if (!rst_n || eng_restart) cnt <= LAT;
    else if (cnt != 0)         cnt <= cnt - 1;
  end

  // reference model state
  logic [31:0] m_l = '0, m_lx = '0, m_r = '0, m_rx = '0, m_c = '0;
  logic        m_ok = 1'b0, m_rst = 1'b1, m_rdv = 1'b0;
  logic [31:0] m_rdd = '0;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input logic v, input logic wf, input logic [3:0] c,
                     input logic [31:0] a, input logic [31:0] b, input string tag);
    logic isres, rdy, acc, flt, wr, rdv;
    logic [7:0]  mfl;
    logic [31:0] nl, nlx, nr, nrx, nc, rdd, res, resx;
    cmd_valid = v; cmd_wfunc = wf; cmd_code = c; data_a = a; data_b = b;
    #5;
    isres = (c == 6 || c == 7 || c == 14 || c == 15);
    rdy   = !(isres && !m_ok);
    acc   = v && rdy;
    mfl   = m_c[23:16] | {2'b00, eflags};
    flt   = acc && isres && ((mfl & m_c[31:24]) != 0);
    chk(tag, "cmd_ready", {31'd0, cmd_ready}, {31'd0, rdy});
    chk(tag, "fault", {31'd0, fault}, {31'd0, flt});
    res = m_l + m_r; resx = m_lx ^ m_rx;
    nl = m_l; nlx = m_lx; nr = m_r; nrx = m_rx; nc = m_c;
    wr = 0; rdv = 0; rdd = m_rdd;
    if (acc) begin
      if (isres) nc[23:16] = mfl;
      if (wf && !(c == 1 || c == 3 || c == 5)) begin nc[7:0] = a[7:0]; wr = 1; end
      if (!flt) begin
        case (c)
          0: begin nl = b; wr = 1; end
          1: begin nl = b; nlx = a; wr = 1; end
          2: begin nr = b; wr = 1; end
          3: begin nr = b; nrx = a; wr = 1; end
          4: begin nc = b; wr = 1; end
          5: begin nl = b; nr = a; wr = 1; end
          6: begin nl = res; nlx = resx; wr = 1; end
          7: begin nr = res; nrx = resx; wr = 1; end
          8: begin rdv = 1; rdd = m_l; end
          9: begin rdv = 1; rdd = m_lx; end
          10: begin rdv = 1; rdd = m_r; end
          11: begin rdv = 1; rdd = m_rx; end
          12: begin rdv = 1; rdd = m_c; end
          13: begin rdv = 1; rdd = '0; end
          14: begin rdv = 1; rdd = res; end
          default: begin rdv = 1; rdd = resx; end
        endcase
      end
    end
    if (wr) m_ok = 0;
    else if (eng_done && !m_rst) m_ok = 1;
    m_rst = wr;
    m_l = nl; m_lx = nlx; m_r = nr; m_rx = nrx; m_c = nc; m_rdv = rdv; m_rdd = rdd;
    @(posedge clk); #5;
    chk(tag, "op_left", op_left, m_l);
    chk(tag, "op_leftx", op_leftx, m_lx);
    chk(tag, "op_right", op_right, m_r);
    chk(tag, "op_rightx", op_rightx, m_rx);
    chk(tag, "op_ctrl", op_ctrl, m_c);
    chk(tag, "rd_valid", {31'd0, rd_valid}, {31'd0, m_rdv});
    if (m_rdv) chk(tag, "rd_data", rd_data, m_rdd);
    chk(tag, "eng_restart", {31'd0, eng_restart}, {31'd0, m_rst});
    @(negedge clk);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(0, 0, 4'd0, '0, '0, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    cyc(0, 0, 4'd8, '0, '0, "R11");
    idle(5, "R10");
    // R1 operand loads
    cyc(1, 0, 4'd0, 32'hAAAA0000, 32'h00000011, "R1");
    cyc(1, 0, 4'd1, 32'h1234ABCD, 32'h00000022, "R1");
    cyc(1, 0, 4'd2, 32'hFFFF0000, 32'h00000033, "R1");
    cyc(1, 0, 4'd3, 32'h0F0F0F0F, 32'h00000044, "R1");
    // R2 Control and split load
    cyc(1, 0, 4'd4, 32'h55555555, 32'h00003C05, "R2");
    cyc(1, 0, 4'd5, 32'h00000700, 32'h00000100, "R2");
    // R4 plain reads
    for (int k = 8; k <= 13; k++) cyc(1, 0, 4'(k), 32'hDEAD0000, 32'hBEEF0000, "R4");
    // R7 result read held while rejected
    cyc(1, 0, 4'd0, '0, 32'h00000005, "R10");
    for (int k = 0; k < 6; k++) cyc(1, 0, 4'd14, '0, '0, "R7");
    cyc(1, 0, 4'd15, '0, '0, "R4");
    // R3 result copies
    cyc(1, 0, 4'd6, '0, '0, "R3");
    idle(5, "R3");
    cyc(1, 0, 4'd7, '0, '0, "R3");
    idle(5, "R3");
    // R5 function write alone, then with Control write
    cyc(1, 1, 4'd8, 32'h000000A7, '0, "R5");
    cyc(1, 0, 4'd12, '0, '0, "R5");
    cyc(1, 1, 4'd4, 32'h000000EE, 32'h00001122, "R5");
    cyc(1, 0, 4'd12, '0, '0, "R5");
    // R6 illegal function write ignored
    cyc(1, 1, 4'd1, 32'h00000099, 32'h00000077, "R6");
    cyc(1, 1, 4'd5, 32'h00000066, 32'h00000088, "R6");
    cyc(1, 0, 4'd12, '0, '0, "R6");
    // function write together with a result copy
    idle(5, "R5");
    cyc(1, 1, 4'd6, 32'h00000042, '0, "R5");
    // R8 flag merge, mask clear
    eflags = 6'h10;
    idle(5, "R8");
    cyc(1, 0, 4'd15, '0, '0, "R8");
    cyc(1, 0, 4'd12, '0, '0, "R8");
    // R9 enabled flag faults a copy and a read
    cyc(1, 0, 4'd4, '0, 32'h01000000, "R9");
    eflags = 6'h01;
    idle(5, "R9");
    cyc(1, 0, 4'd7, '0, '0, "R9");
    cyc(1, 0, 4'd14, '0, '0, "R9");
    cyc(1, 0, 4'd12, '0, '0, "R9");
    eflags = 6'h00;
    cyc(1, 0, 4'd4, '0, 32'h00000000, "R9");
    idle(5, "R9");
    cyc(1, 0, 4'd7, '0, '0, "R9");
    idle(2, "R10");
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule